// File: doc/BRIEF.md
# Periodic Tick Timer with Silent Ticks and One-Shot Wake

The block is a system timer that works from a free-running 64-bit microsecond timebase supplied at its input. It holds two deadlines. The periodic tick deadline starts one period after reset. Each time the timebase reaches it, the deadline moves forward by exactly one period and a tick interrupt is sent to the interrupt controller. A software-loaded count of silent ticks can suppress a number of these interrupts without disturbing the cadence. The one-shot wake deadline is disarmed by default, which is represented as all ones. Once software arms it, the timebase reaching it disarms it again and sends a single hard wake pulse. That pulse has no status bit behind it.

The earliest of the two deadlines is always presented at an output. An idle or skip-ahead controller can use it to decide how far the timebase may jump. One configuration write port sets the period, loads the silent count and arms the wake deadline. The tick interrupt and the wake request are single-cycle pulses that suit the raise inputs of an interrupt controller.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the tick deadline is 10000, the wake deadline is disarmed (all ones), the silent count is 0, the next-deadline output reads 10000, and both pulse outputs are low.
- R2: When a clock edge sees the timebase at or beyond the tick deadline, the tick deadline becomes the old deadline plus the period. It is not reloaded from the timebase, even when the timebase has overshot.
- R3: A tick expiry with a silent count of zero drives tickIrq high for exactly the one cycle that follows the expiry edge.
- R4: A tick expiry with a non-zero silent count decrements the count by one and raises no tick interrupt, while the deadline still advances by one period.
- R5: A configuration write with select 2 arms the wake deadline. When an edge sees the armed deadline at or below the timebase, the deadline returns to all ones and wakeHard is high for exactly one cycle.
- R6: A wake deadline written with a value already below the timebase fires on the edge after the write.
- R7: nextDeadline always equals the smaller of the tick deadline and the wake deadline, and it follows every change to either one.
- R8: When the wake and tick deadlines share one timebase value, both are serviced on the same edge. The wake pulse and the tick pulse appear in the same cycle, and both deadlines are updated.
- R9: A configuration write with select 0 sets the period that later advances use, and a period value of zero is ignored. A write with select 1 loads the silent count.
- R10: When the timebase lies several periods past the tick deadline, the deadline advances by one period on each cycle. Each step is a separate expiry, and it continues until the deadline exceeds the timebase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nowTime | input | 64 | Free-running timebase value in microseconds |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Write target: 0 period, 1 silent count, 2 wake deadline |
| cfgData | input | 64 | Write data |
| tickIrq | output | 1 | Single-cycle tick interrupt pulse |
| wakeHard | output | 1 | Single-cycle hard wake pulse |
| nextDeadline | output | 64 | Earliest pending deadline |

## Verification
The bench builds the block with its default parameters: a 64-bit timebase, a 32-bit period, a 16-bit silent count and a reset period of 10000. The timebase is an input, so the bench moves it in large jumps rather than counting through it. This puts expiries at the reset deadline, overshoots of the tick deadline, backlogs of several periods and deadlines already in the past within a few dozen cycles. Coincident wake and tick deadlines and the effect of a zero period are reached the same way.

// File: rtl/tick_pkg.sv
package tick_pkg;

  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_SILENT = 2'd1,
    SEL_WAKE   = 2'd2
  } cfg_sel_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic tickAdvance;
    logic silentDec;
    logic wakeDisarm;
    logic loadPeriod;
    logic loadSilent;
    logic loadWake;
  } strobe_t;

endpackage

// File: rtl/deadline_cmp.sv
module deadline_cmp #(
  parameter int TIME_W    = 64,
  parameter bit HAS_NEVER = 1'b0
) (
  input  logic [TIME_W-1:0] nowTime,
  input  logic [TIME_W-1:0] deadline,
  output logic              hit
);

  logic reached;
  assign reached = (deadline <= nowTime);

  generate
    if (HAS_NEVER) begin : g_never
      assign hit = reached && (deadline != {TIME_W{1'b1}});
    end else begin : g_plain
      assign hit = reached;
    end
  endgenerate

endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickHit,
  input  logic       wakeHit,
  input  logic       silentZero,
  input  logic       cfgZero,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgSel,
  output strobe_t    strb,
  output logic       tickIrq,
  output logic       wakeHard
);

  logic selPeriod, selSilent, selWake;
  assign selPeriod = cfgWrEn && (cfgSel == SEL_PERIOD);
  assign selSilent = cfgWrEn && (cfgSel == SEL_SILENT);
  assign selWake   = cfgWrEn && (cfgSel == SEL_WAKE);

  always_comb begin
    strb             = '0;
    strb.tickAdvance = tickHit;
    strb.silentDec   = tickHit && !silentZero && !selSilent;
    strb.wakeDisarm  = wakeHit;
    strb.loadPeriod  = selPeriod && !cfgZero;
    strb.loadSilent  = selSilent;
    strb.loadWake    = selWake;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tickIrq  <= 1'b0;
      wakeHard <= 1'b0;
    end else begin
      tickIrq  <= tickHit && silentZero;
      wakeHard <= wakeHit;
    end
  end

  // R3
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tickIrq |-> $past(tickHit) && $past(silentZero));

  // R5
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wakeHard |-> $past(wakeHit));

  // R4
  silent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tickHit && !silentZero) |=> !tickIrq);

endmodule

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_pkg::*;
#(
  parameter int TIME_W       = 64,
  parameter int PER_W        = 32,
  parameter int SILENT_W     = 16,
  parameter int PERIOD_RESET = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] nowTime,
  input  logic [TIME_W-1:0] cfgData,
  input  strobe_t           strb,
  output logic              tickHit,
  output logic              wakeHit,
  output logic              silentZero,
  output logic              cfgZero,
  output logic [TIME_W-1:0] nextDeadline
);

  localparam logic [TIME_W-1:0] NEVER     = {TIME_W{1'b1}};
  localparam logic [PER_W-1:0]  PER_INIT  = PER_W'(PERIOD_RESET);
  localparam logic [TIME_W-1:0] TICK_INIT = TIME_W'(PERIOD_RESET);

  logic [PER_W-1:0]    periodReg;
  logic [TIME_W-1:0]   tickDl;
  logic [TIME_W-1:0]   wakeDl;
  logic [SILENT_W-1:0] silentCnt;

  deadline_cmp #(.TIME_W(TIME_W), .HAS_NEVER(1'b0)) tickCmp_i (
    .nowTime (nowTime),
    .deadline(tickDl),
    .hit     (tickHit)
  );

  deadline_cmp #(.TIME_W(TIME_W), .HAS_NEVER(1'b1)) wakeCmp_i (
    .nowTime (nowTime),
    .deadline(wakeDl),
    .hit     (wakeHit)
  );

  assign silentZero   = (silentCnt == '0);
  assign cfgZero      = (cfgData[PER_W-1:0] == '0);
  assign nextDeadline = (wakeDl < tickDl) ? wakeDl : tickDl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      periodReg <= PER_INIT;
      tickDl    <= TICK_INIT;
      wakeDl    <= NEVER;
      silentCnt <= '0;
    end else begin
      if (strb.loadPeriod) periodReg <= cfgData[PER_W-1:0];
      if (strb.tickAdvance) tickDl <= tickDl + TIME_W'(periodReg);
      if (strb.loadSilent) silentCnt <= cfgData[SILENT_W-1:0];
      else if (strb.silentDec) silentCnt <= silentCnt - 1'b1;
      if (strb.loadWake) wakeDl <= cfgData;
      else if (strb.wakeDisarm) wakeDl <= NEVER;
    end
  end

  // R2
  tick_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tickDl) |-> $past(strb.tickAdvance));

  // R4
  silent_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tickHit && !silentZero && !strb.loadSilent) |=> silentCnt == $past(silentCnt) - 1'b1);

  // R5
  wake_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wakeHit && !strb.loadWake) |=> wakeDl == NEVER);

  // R7
  next_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nextDeadline <= tickDl) && (nextDeadline <= wakeDl));

  // R9
  period_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periodReg != '0);

endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import tick_pkg::*;
#(
  parameter int TIME_W       = 64,
  parameter int PER_W        = 32,
  parameter int SILENT_W     = 16,
  parameter int PERIOD_RESET = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] nowTime,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [TIME_W-1:0] cfgData,
  output logic              tickIrq,
  output logic              wakeHard,
  output logic [TIME_W-1:0] nextDeadline
);

  strobe_t strb;
  logic    tickHit, wakeHit, silentZero, cfgZero;

  tick_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tickHit   (tickHit),
    .wakeHit   (wakeHit),
    .silentZero(silentZero),
    .cfgZero   (cfgZero),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .strb      (strb),
    .tickIrq   (tickIrq),
    .wakeHard  (wakeHard)
  );

  tick_datapath #(
    .TIME_W      (TIME_W),
    .PER_W       (PER_W),
    .SILENT_W    (SILENT_W),
    .PERIOD_RESET(PERIOD_RESET)
  ) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .nowTime     (nowTime),
    .cfgData     (cfgData),
    .strb        (strb),
    .tickHit     (tickHit),
    .wakeHit     (wakeHit),
    .silentZero  (silentZero),
    .cfgZero     (cfgZero),
    .nextDeadline(nextDeadline)
  );

endmodule

// File: tb/sys_tick_timer_tb_top.sv
`timescale 1ns/1ps
module sys_tick_timer_tb_top;

  localparam logic [63:0] NEVER = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] nowTime = '0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [63:0] cfgData = '0;
  logic        tickIrq, wakeHard;
  logic [63:0] nextDeadline;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sys_tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .nowTime(nowTime),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .tickIrq(tickIrq), .wakeHard(wakeHard), .nextDeadline(nextDeadline)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one edge, then sample at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [63:0] data);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = data;
    step();
    cfgWrEn = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; nowTime = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 next deadline", nextDeadline, 64'd10000);
    chk("R1 tickIrq low", tickIrq, 0);
    chk("R1 wakeHard low", wakeHard, 0);
  endtask

  task automatic t_basic_tick();
    nowTime = 9999; step();
    chk("R3 no tick before deadline", tickIrq, 0);
    chk("R2 deadline held", nextDeadline, 64'd10000);
    nowTime = 10000; step();
    chk("R3 tick pulse", tickIrq, 1);
    chk("R2 advance", nextDeadline, 64'd20000);
    step();
    chk("R3 pulse one cycle", tickIrq, 0);
  endtask

  task automatic t_overshoot();
    nowTime = 25000; step();
    chk("R3 tick on overshoot", tickIrq, 1);
    chk("R2 advance by period not from time", nextDeadline, 64'd30000);
    step();
    chk("R3 pulse ends", tickIrq, 0);
  endtask

  task automatic t_silent();
    cfgWrite(2'd1, 64'd2);   // R9 load silent count
    nowTime = 30000; step();
    chk("R4 first silent tick", tickIrq, 0);
    chk("R4 cadence kept", nextDeadline, 64'd40000);
    nowTime = 40000; step();
    chk("R4 second silent tick", tickIrq, 0);
    chk("R4 cadence kept 2", nextDeadline, 64'd50000);
    nowTime = 50000; step();
    chk("R4 count exhausted, tick returns", tickIrq, 1);
    chk("R4 deadline", nextDeadline, 64'd60000);
    step();
  endtask

  task automatic t_wake();
    cfgWrite(2'd2, 64'd55000);
    chk("R7 min picks wake", nextDeadline, 64'd55000);
    step();
    chk("R5 no wake early", wakeHard, 0);
    nowTime = 55000; step();
    chk("R5 wake pulse", wakeHard, 1);
    chk("R5 disarm returns tick to min", nextDeadline, 64'd60000);
    chk("R5 no tick", tickIrq, 0);
    step();
    chk("R5 pulse one cycle", wakeHard, 0);
  endtask

  task automatic t_past_wake();
    cfgWrite(2'd2, 64'd100);
    chk("R6 armed in past", nextDeadline, 64'd100);
    chk("R6 not yet fired", wakeHard, 0);
    step();
    chk("R6 fires next cycle", wakeHard, 1);
    chk("R6 disarmed", nextDeadline, 64'd60000);
    step();
  endtask

  task automatic t_coincide();
    cfgWrite(2'd2, 64'd60000);
    nowTime = 60000; step();
    chk("R8 wake pulse", wakeHard, 1);
    chk("R8 tick pulse", tickIrq, 1);
    chk("R8 both updated", nextDeadline, 64'd70000);
    step();
    chk("R8 wake ends", wakeHard, 0);
    chk("R8 tick ends", tickIrq, 0);
  endtask

  task automatic t_period();
    cfgWrite(2'd0, 64'd5000);
    cfgWrite(2'd0, 64'd0);   // zero must be ignored
    nowTime = 70000; step();
    chk("R9 tick with new period", tickIrq, 1);
    chk("R9 new period, zero ignored", nextDeadline, 64'd75000);
    step();
    chk("R9 single expiry", tickIrq, 0);
    chk("R9 deadline stays", nextDeadline, 64'd75000);
  endtask

  task automatic t_catchup();
    nowTime = 90000;
    for (int k = 1; k <= 4; k++) begin
      step();
      chk("R10 backlog tick", tickIrq, 1);
      chk("R10 one period per cycle", nextDeadline, 64'd75000 + 64'(k) * 64'd5000);
    end
    step();
    chk("R10 backlog cleared", tickIrq, 0);
    chk("R10 final deadline", nextDeadline, 64'd95000);
    cfgWrite(2'd2, 64'd200000);
    chk("R7 min picks tick", nextDeadline, 64'd95000);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic_tick();
    t_overshoot();
    t_silent();
    t_wake();
    t_past_wake();
    t_coincide();
    t_period();
    t_catchup();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
    end
  end

endmodule